// File: doc/BRIEF.md
# Node Control Command Decoder

This block listens to the local byte stream that an upstream packet splitter delivers to one node. The stream carries one byte per valid strobe, a start-of-packet pulse on the first byte of each packet, and an end-of-packet pulse once the packet is over. Every packet opens with a four-byte header. The header holds a start marker, a slot byte, a byte that packs a sub-channel nibble above a command nibble, and a payload length.

The block acts only on packets that meet three conditions: they are addressed to this node, they name the control sub-channel, and their header starts correctly. For such a packet it decodes the command nibble. Some commands update persistent pin-mode settings: the readback-pin function, the serial input enable, the serial output enable and the boot-image choice. Other commands raise single-cycle action strobes: core reset, baud-lock clear and device-ID report. One command latches a power-off request, which holds until reset.

Each command takes effect on the clock edge that accepts the command byte. All outputs are registered, so the new value appears in the cycle that follows the command byte.

Top module: `node_ctl_decoder`

## Requirements
- R1: During and after synchronous reset (`rst` high): `rb_sel`=0, `rx_pin_en`=1, `tx_pin_en`=1, `pwr_off_req`=0, `boot_user`=0, and all three action strobes are 0.
- R2: A packet is decoded only if its first byte, marked by `pkt_sop` with `byte_vld`, equals 0xF0. Valid bytes after it count as slot (second), command (third) and length (fourth). A packet with any other first byte changes nothing.
- R3: The command byte takes effect only when its upper nibble (bits 7:4) is 0xF. Any other sub-channel changes nothing.
- R4: The node is addressed when the slot byte is 0x00 or 0xFF. Any other slot value, including 0xFE, changes nothing.
- R5: Command nibbles 0x0 to 0x3 load `rb_sel` with that value (0 readback, 1 loopback, 2 interrupt, 3 user). The new value is visible in the cycle after the command byte, and `rb_sel` holds between commands.
- R6: Command 0x4 sets `rx_pin_en` to 1 and 0x5 clears it. Command 0x6 sets `tx_pin_en` to 1 and 0x7 clears it.
- R7: Command nibbles 0x8 and 0x9 change no output.
- R8: Command 0xA pulses `id_report`, 0xB pulses `core_rst`, and 0xC pulses `baud_clr`. Each pulse is high for exactly one cycle, the cycle after the command byte.
- R9: Command 0xD sets `pwr_off_req`, which stays 1 until reset.
- R10: Command 0xE clears `boot_user` (bootloader image) and 0xF sets it (user image).
- R11: Payload bytes are ignored, and so are valid bytes that arrive after `pkt_eop` but before the next `pkt_sop`, even when they look like control commands.
- R12: Only the third byte of a packet is read as a command. A length byte of the form 0xFx has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| byte_in | input | 8 | Local stream byte |
| byte_vld | input | 1 | Byte valid strobe |
| pkt_sop | input | 1 | Start of packet, qualified by byte_vld |
| pkt_eop | input | 1 | End of packet pulse |
| rb_sel | output | 2 | Readback-pin function select |
| rx_pin_en | output | 1 | Serial input pin enable |
| tx_pin_en | output | 1 | Serial output pin enable |
| core_rst | output | 1 | One-cycle core reset strobe |
| baud_clr | output | 1 | One-cycle baud-lock clear strobe |
| id_report | output | 1 | One-cycle device-ID report strobe |
| pwr_off_req | output | 1 | Sticky power-off request |
| boot_user | output | 1 | Boot image select, 1 = user image |

## Verification
On every cycle the assertions check the following. At most one command fires per packet. An end-of-packet pulse blocks any command in the next cycle. Each action strobe lasts one cycle, and the strobes never overlap. The power-off request never falls without reset. The readback select moves only on a decoded command. The bench scenarios show the things a single-cycle property cannot: address filtering, sub-channel filtering, rejection of a bad start byte, the no-effect cases for reserved codes, payload bytes and length bytes, and stray bytes after a packet ends. A behavioural model compares every output on every clock.

// File: rtl/ndc_pkg.sv
package ndc_pkg;

  typedef struct packed {
    logic       ld_rb;
    logic [1:0] rb_val;
    logic       ld_rx;
    logic       rx_val;
    logic       ld_tx;
    logic       tx_val;
    logic       do_id;
    logic       do_rst;
    logic       do_baud;
    logic       do_pwr;
    logic       ld_boot;
    logic       boot_val;
  } ctl_op_t;

  // Slot values that address this node: own slot or broadcast.
  function automatic logic slot_hits(input logic [7:0] slot,
                                     input logic [7:0] self_id,
                                     input logic [7:0] all_id);
    return (slot == self_id) || (slot == all_id);
  endfunction

  // Command nibble to operation.
  function automatic ctl_op_t map_cmd(input logic [3:0] code);
    ctl_op_t op;
    op = '0;
    case (code)
      4'h0, 4'h1, 4'h2, 4'h3: begin op.ld_rb = 1'b1; op.rb_val = code[1:0]; end
      4'h4, 4'h5: begin op.ld_rx = 1'b1; op.rx_val = ~code[0]; end
      4'h6, 4'h7: begin op.ld_tx = 1'b1; op.tx_val = ~code[0]; end
      4'hA: op.do_id   = 1'b1;
      4'hB: op.do_rst  = 1'b1;
      4'hC: op.do_baud = 1'b1;
      4'hD: op.do_pwr  = 1'b1;
      4'hE, 4'hF: begin op.ld_boot = 1'b1; op.boot_val = code[0]; end
      default: op = '0;
    endcase
    return op;
  endfunction

endpackage

// File: rtl/ndc_hdr_track.sv
module ndc_hdr_track #(
  parameter int          BYTE_W     = 8,
  parameter logic [7:0]  START_BYTE = 8'hF0,
  parameter logic [7:0]  SLOT_SELF  = 8'h00,
  parameter logic [7:0]  SLOT_ALL   = 8'hFF,
  parameter logic [3:0]  CTL_SUBCH  = 4'hF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              byte_vld,
  input  logic              pkt_sop,
  input  logic              pkt_eop,
  output logic              cmd_fire,
  output logic [3:0]        cmd_code
);
  import ndc_pkg::*;

  localparam int NIB_W   = BYTE_W / 2;
  localparam int HDR_LEN = 4;
  localparam int IDX_W   = $clog2(HDR_LEN + 1);
  localparam logic [IDX_W-1:0] IDX_SLOT = IDX_W'(1);
  localparam logic [IDX_W-1:0] IDX_CMD  = IDX_W'(2);
  localparam logic [IDX_W-1:0] IDX_END  = IDX_W'(HDR_LEN);

  logic              active;
  logic [IDX_W-1:0]  idx;
  logic [BYTE_W-1:0] slot_q;
  logic              body_byte;
  logic              at_cmd;
  logic              addressed;
  logic              subch_ok;

  assign body_byte = byte_vld && !pkt_sop && active;
  assign at_cmd    = body_byte && (idx == IDX_CMD);
  assign addressed = slot_hits(slot_q, SLOT_SELF, SLOT_ALL);
  assign subch_ok  = byte_in[BYTE_W-1 -: NIB_W] == CTL_SUBCH;
  assign cmd_fire  = at_cmd && addressed && subch_ok;
  assign cmd_code  = byte_in[NIB_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      idx    <= '0;
      slot_q <= '0;
    end else begin
      if (byte_vld && pkt_sop) begin
        active <= (byte_in == START_BYTE);
        idx    <= IDX_SLOT;
      end else if (body_byte) begin
        if (idx == IDX_SLOT) slot_q <= byte_in;
        if (idx != IDX_END)  idx    <= idx + 1'b1;
      end
      if (pkt_eop) active <= 1'b0;
    end
  end

  a_r12_single_cmd: assert property (@(posedge clk) disable iff (rst)
    cmd_fire |=> !cmd_fire);

  a_r11_closed_after_eop: assert property (@(posedge clk) disable iff (rst)
    pkt_eop |=> !cmd_fire);

endmodule

// File: rtl/ndc_ctl_regs.sv
module ndc_ctl_regs (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  ndc_pkg::ctl_op_t op,
  output logic [1:0]       rb_sel,
  output logic             rx_pin_en,
  output logic             tx_pin_en,
  output logic             core_rst,
  output logic             baud_clr,
  output logic             id_report,
  output logic             pwr_off_req,
  output logic             boot_user
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rb_sel      <= 2'd0;
      rx_pin_en   <= 1'b1;
      tx_pin_en   <= 1'b1;
      core_rst    <= 1'b0;
      baud_clr    <= 1'b0;
      id_report   <= 1'b0;
      pwr_off_req <= 1'b0;
      boot_user   <= 1'b0;
    end else begin
      core_rst  <= fire && op.do_rst;
      baud_clr  <= fire && op.do_baud;
      id_report <= fire && op.do_id;
      if (fire) begin
        if (op.ld_rb)   rb_sel      <= op.rb_val;
        if (op.ld_rx)   rx_pin_en   <= op.rx_val;
        if (op.ld_tx)   tx_pin_en   <= op.tx_val;
        if (op.do_pwr)  pwr_off_req <= 1'b1;
        if (op.ld_boot) boot_user   <= op.boot_val;
      end
    end
  end

  a_r8_strobe_one_cycle: assert property (@(posedge clk) disable iff (rst)
    (core_rst || baud_clr || id_report) |=> !(core_rst || baud_clr || id_report));

  a_r8_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({core_rst, baud_clr, id_report}));

  a_r9_pwr_sticky: assert property (@(posedge clk) disable iff (rst)
    pwr_off_req |=> pwr_off_req);

  a_r5_sel_holds: assert property (@(posedge clk) disable iff (rst)
    !fire |=> $stable(rb_sel));

endmodule

// File: rtl/node_ctl_decoder.sv
module node_ctl_decoder #(
  parameter int         BYTE_W     = 8,
  parameter logic [7:0] START_BYTE = 8'hF0,
  parameter logic [7:0] SLOT_SELF  = 8'h00,
  parameter logic [7:0] SLOT_ALL   = 8'hFF,
  parameter logic [3:0] CTL_SUBCH  = 4'hF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              byte_vld,
  input  logic              pkt_sop,
  input  logic              pkt_eop,
  output logic [1:0]        rb_sel,
  output logic              rx_pin_en,
  output logic              tx_pin_en,
  output logic              core_rst,
  output logic              baud_clr,
  output logic              id_report,
  output logic              pwr_off_req,
  output logic              boot_user
);
  import ndc_pkg::*;

  logic       cmd_fire;
  logic [3:0] cmd_code;
  ctl_op_t    cmd_op;

  ndc_hdr_track #(
    .BYTE_W(BYTE_W), .START_BYTE(START_BYTE), .SLOT_SELF(SLOT_SELF),
    .SLOT_ALL(SLOT_ALL), .CTL_SUBCH(CTL_SUBCH)
  ) u_track (
    .clk(clk), .rst(rst), .byte_in(byte_in), .byte_vld(byte_vld),
    .pkt_sop(pkt_sop), .pkt_eop(pkt_eop),
    .cmd_fire(cmd_fire), .cmd_code(cmd_code)
  );

  assign cmd_op = map_cmd(cmd_code);

  ndc_ctl_regs u_regs (
    .clk(clk), .rst(rst), .fire(cmd_fire), .op(cmd_op),
    .rb_sel(rb_sel), .rx_pin_en(rx_pin_en), .tx_pin_en(tx_pin_en),
    .core_rst(core_rst), .baud_clr(baud_clr), .id_report(id_report),
    .pwr_off_req(pwr_off_req), .boot_user(boot_user)
  );

  a_r11_fire_needs_byte: assert property (@(posedge clk) disable iff (rst)
    cmd_fire |-> (byte_vld && !pkt_sop));

endmodule

// File: tb/node_ctl_decoder_bench.sv
module node_ctl_decoder_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] byte_in = 8'h00;
  logic       byte_vld = 1'b0, pkt_sop = 1'b0, pkt_eop = 1'b0;
  logic [1:0] rb_sel;
  logic rx_pin_en, tx_pin_en, core_rst, baud_clr, id_report, pwr_off_req, boot_user;

  always #2.5 clk = ~clk;

  node_ctl_decoder u_node_ctl_decoder (
    .clk(clk), .rst(rst), .byte_in(byte_in), .byte_vld(byte_vld),
    .pkt_sop(pkt_sop), .pkt_eop(pkt_eop), .rb_sel(rb_sel),
    .rx_pin_en(rx_pin_en), .tx_pin_en(tx_pin_en), .core_rst(core_rst),
    .baud_clr(baud_clr), .id_report(id_report), .pwr_off_req(pwr_off_req),
    .boot_user(boot_user)
  );

  int checks = 0, failures = 0;
  bit done = 0, live = 0;
  int n_rst = 0, n_baud = 0, n_id = 0;

  // Behavioural reference model
  int m_rb = 0, m_rx = 1, m_tx = 1, m_crst = 0, m_baud = 0, m_id = 0, m_pwr = 0, m_boot = 0;
  int m_pos = 0, m_slot = 0;
  bit m_open = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_rb = 0; m_rx = 1; m_tx = 1; m_crst = 0; m_baud = 0; m_id = 0;
      m_pwr = 0; m_boot = 0; m_open = 0; m_pos = 0; m_slot = 0;
    end else begin
      m_crst = 0; m_baud = 0; m_id = 0;
      if (byte_vld) begin
        if (pkt_sop) begin
          m_open = (byte_in == 8'hF0);
          m_pos = 1;
        end else if (m_open) begin
          if (m_pos == 1) m_slot = byte_in;
          if (m_pos == 2 && (m_slot == 0 || m_slot == 255) && byte_in / 16 == 15) begin
            int c;
            c = byte_in % 16;
            if (c < 4) m_rb = c;
            else if (c == 4) m_rx = 1;
            else if (c == 5) m_rx = 0;
            else if (c == 6) m_tx = 1;
            else if (c == 7) m_tx = 0;
            else if (c == 10) m_id = 1;
            else if (c == 11) m_crst = 1;
            else if (c == 12) m_baud = 1;
            else if (c == 13) m_pwr = 1;
            else if (c == 14) m_boot = 0;
            else if (c == 15) m_boot = 1;
          end
          m_pos = m_pos + 1;
        end
      end
      if (pkt_eop) m_open = 0;
    end
    if (!rst) begin
      n_rst += core_rst; n_baud += baud_clr; n_id += id_report;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (live) begin
    check("R5 rb_sel per-cycle", rb_sel, m_rb);
    check("R6 rx_pin_en per-cycle", rx_pin_en, m_rx);
    check("R6 tx_pin_en per-cycle", tx_pin_en, m_tx);
    check("R8 core_rst per-cycle", core_rst, m_crst);
    check("R8 baud_clr per-cycle", baud_clr, m_baud);
    check("R8 id_report per-cycle", id_report, m_id);
    check("R9 pwr_off_req per-cycle", pwr_off_req, m_pwr);
    check("R10 boot_user per-cycle", boot_user, m_boot);
  end

  task automatic put(input logic [7:0] b, input bit sop);
    @(negedge clk);
    byte_in = b; byte_vld = 1'b1; pkt_sop = sop; pkt_eop = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      byte_vld = 1'b0; pkt_sop = 1'b0; pkt_eop = 1'b0; byte_in = 8'h00;
    end
  endtask

  task automatic finish_pkt();
    @(negedge clk);
    byte_vld = 1'b0; pkt_sop = 1'b0; pkt_eop = 1'b1;
    idle(2);
  endtask

  // Full packet: start, slot, sub/cmd, length, then length payload bytes
  task automatic pkt(input logic [7:0] st, input logic [7:0] slot,
                     input logic [7:0] sc, input logic [7:0] len,
                     input logic [7:0] pay);
    put(st, 1'b1); put(slot, 1'b0); put(sc, 1'b0); put(len, 1'b0);
    for (int i = 0; i < len; i++) put(pay, 1'b0);
    finish_pkt();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    live = 1;
    @(negedge clk);
    check("R1 rb_sel reset", rb_sel, 0);
    check("R1 rx_pin_en reset", rx_pin_en, 1);
    check("R1 tx_pin_en reset", tx_pin_en, 1);
    check("R1 pwr_off_req reset", pwr_off_req, 0);
    check("R1 boot_user reset", boot_user, 0);
    check("R1 strobes reset", core_rst | baud_clr | id_report, 0);
    rst = 1'b0;
    idle(2);

    // R5 readback modes, each visible the cycle after the command byte
    for (int c = 1; c <= 3; c++) begin
      put(8'hF0, 1); put(8'h00, 0); put(8'hF0 | c[7:0], 0); put(8'h00, 0);
      @(negedge clk); check("R5 rb_sel after cmd", rb_sel, c);
      finish_pkt();
    end
    pkt(8'hF0, 8'h00, 8'hF0, 8'h00, 8'h00);
    check("R5 rb_sel back to readback", rb_sel, 0);

    // R6 pin enables
    pkt(8'hF0, 8'h00, 8'hF5, 8'h00, 8'h00); check("R6 rx disabled", rx_pin_en, 0);
    pkt(8'hF0, 8'hFF, 8'hF7, 8'h00, 8'h00); check("R6 tx disabled", tx_pin_en, 0);
    pkt(8'hF0, 8'h00, 8'hF4, 8'h00, 8'h00); check("R6 rx enabled", rx_pin_en, 1);

    // R7 reserved codes
    pkt(8'hF0, 8'h00, 8'hF8, 8'h00, 8'h00);
    pkt(8'hF0, 8'h00, 8'hF9, 8'h00, 8'h00);
    check("R7 reserved keeps rx", rx_pin_en, 1);
    check("R7 reserved keeps tx", tx_pin_en, 0);
    check("R7 reserved keeps boot", boot_user, 0);
    check("R7 reserved no strobes", n_rst + n_baud + n_id, 0);

    // R8 strobes
    pkt(8'hF0, 8'h00, 8'hFB, 8'h00, 8'h00); check("R8 core_rst count", n_rst, 1);
    pkt(8'hF0, 8'hFF, 8'hFC, 8'h00, 8'h00); check("R8 baud_clr count", n_baud, 1);
    pkt(8'hF0, 8'h00, 8'hFA, 8'h02, 8'h33); check("R8 id_report count", n_id, 1);

    // R10 boot select, R9 sticky power-off
    pkt(8'hF0, 8'h00, 8'hFF, 8'h00, 8'h00); check("R10 boot user", boot_user, 1);
    pkt(8'hF0, 8'h00, 8'hFD, 8'h00, 8'h00); check("R9 pwr_off set", pwr_off_req, 1);
    pkt(8'hF0, 8'h00, 8'hFE, 8'h00, 8'h00); check("R10 boot loader", boot_user, 0);
    check("R9 pwr_off holds", pwr_off_req, 1);

    // R3 wrong sub-channel
    pkt(8'hF0, 8'h00, 8'hE5, 8'h00, 8'h00); check("R3 other subch ignored", rx_pin_en, 1);
    // R4 null slot and foreign slot
    pkt(8'hF0, 8'hFE, 8'hF5, 8'h00, 8'h00); check("R4 null slot ignored", rx_pin_en, 1);
    pkt(8'hF0, 8'h07, 8'hF2, 8'h00, 8'h00); check("R4 other slot ignored", rb_sel, 0);
    // R2 bad start byte
    pkt(8'hF1, 8'h00, 8'hF3, 8'h00, 8'h00); check("R2 bad start ignored", rb_sel, 0);
    // R12 length byte shaped as command
    pkt(8'hF0, 8'h00, 8'h12, 8'hF5, 8'hF5); check("R12 length byte ignored", rx_pin_en, 1);
    // R11 payload bytes and stray bytes after end of packet
    pkt(8'hF0, 8'h00, 8'h30, 8'h03, 8'hF3); check("R11 payload ignored", rb_sel, 0);
    put(8'h00, 0); put(8'hF5, 0); put(8'hF5, 0); idle(2);
    check("R11 stray bytes ignored", rx_pin_en, 1);
    // R2 header works with gaps between bytes
    put(8'hF0, 1); idle(1); put(8'h00, 0); idle(2); put(8'hF6, 0); finish_pkt();
    check("R2 gapped header decoded", tx_pin_en, 1);

    // R1 reset restores defaults
    @(negedge clk); rst = 1'b1; idle(2);
    check("R1 pwr_off cleared by reset", pwr_off_req, 0);
    rst = 1'b0; idle(2);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule